// File: doc/BRIEF.md
# External Bus Ready-Wait Controller

This block runs single read or write transfers on a separate (non-multiplexed) external bus for slow peripherals behind four chip selects. A transfer starts from a one-cycle request while the block is idle. It then goes through four steps: an address and chip-select setup cycle with the address-latch pulse, an active strobe phase, the programmed software wait states, and a sample of the ready pin. When the transfer finishes the strobe is released and the block raises a one-clock done pulse. For reads, the data is valid on `rdata` in that same cycle.

Each chip select has two settings: a "no wait" bit and a 2-bit software wait field. A chip select with waits enabled gets 1 to 3 software waits. After those waits the block looks at the ready pin once. If ready is low, it holds every bus output still, one cycle at a time, until ready is seen high. A chip select with the no-wait bit set uses a one-cycle strobe and ignores ready entirely. The ready pin goes through a two-stage synchronizer on the falling clock edge, which adds a fixed two-cycle latency. The bus clock output follows the core clock, or is parked high when it is disabled.

Top module: `ebw_ctrl`

## Requirements
- R1: After reset all chip selects, `bus_rd_n`, `bus_wr_lo_n`, `bus_wr_hi_n` and `bus_wr_n` are high, `bus_ale` is low, `bus_dout_oe` is low and `done` is low.
- R2: The cycle after a request is accepted is a setup cycle. In it `bus_ale` is 1, only chip select `bus_cs_n[req_cs]` is low, `bus_addr` equals the request address, and every strobe is high.
- R3: During the strobe phase a read drives `bus_rd_n` low. A write drives `bus_wr_lo_n` low when `req_be[0]` is 1 and `bus_wr_hi_n` low when `req_be[1]` is 1, with `bus_wr_n` low and `bus_dout_oe` high. `bus_bhe_n` is low exactly when `req_be[1]` is 1.
- R4: For a chip select with `cfg_nowait[i]` = 0, the software wait count is 1 for field `cfg_swait[2i+1:2i]` = 00b, 2 for 01b, and 3 for 10b and 11b. With ready high, the strobe stays low for that many cycles plus one.
- R5: For a chip select with `cfg_nowait[i]` = 1, the strobe lasts exactly one cycle whatever the level of `bus_rdy`.
- R6: If `bus_rdy` is low when the wait count has run out on a wait-enabled chip select, the strobe phase is extended. Once `bus_rdy` rises just after a rising clock edge, the strobe goes high two rising edges later.
- R7: While the strobe is active, including ready waits, `bus_addr`, `bus_cs_n`, `bus_dout`, `bus_bhe_n`, `bus_ale` and the strobe levels do not change.
- R8: In the cycle right after the strobe phase, `done` is 1 for exactly one cycle and every strobe is high. For a read, `rdata` holds the `bus_din` value that was present on the final strobe edge. The next cycle the bus is idle.
- R9: A request raised while a transfer is in progress is ignored.
- R10: With `bclk_off` = 0, `bus_clk` follows `clk`. With `bclk_off` = 1, `bus_clk` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, taken only when idle |
| req_addr | input | AW | Transfer address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_cs | input | CSW | Chip-select number |
| cfg_nowait | input | NCS | Per chip select: 1 = no waits, ready ignored |
| cfg_swait | input | 2*NCS | Per chip select 2-bit software wait field |
| bus_rdy | input | 1 | Ready pin, high = ready |
| bclk_off | input | 1 | 1 parks the bus clock high |
| bus_din | input | 16 | Read data from the bus |
| bus_addr | output | AW | Bus address |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_oe | output | 1 | Data output enable |
| bus_cs_n | output | NCS | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_lo_n | output | 1 | Low-byte write strobe, active low |
| bus_wr_hi_n | output | 1 | High-byte write strobe, active low |
| bus_wr_n | output | 1 | Combined write strobe, active low |
| bus_bhe_n | output | 1 | High byte enable, active low |
| bus_ale | output | 1 | Address-latch enable |
| bus_clk | output | 1 | Bus clock output |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
The hardest case to reach is a ready wait that begins exactly as the software waits run out and ends at a known edge. It depends on the ready level having passed the falling-edge synchronizer before the sample point. The bench therefore drives `bus_rdy` low during idle cycles before issuing the request. It then counts strobe cycles and releases ready just after the rising edge of the third strobe cycle past the programmed waits, so the block must already be in the extra wait. The expected strobe length is then that count plus one. Random chip-select, wait-field and no-wait settings are mixed with held-low ready, so the no-wait path is also seen ignoring a low ready.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STRB  = 3'd2,
    ST_RWAIT = 3'd3,
    ST_END   = 3'd4
  } ebw_state_e;

  localparam int unsigned WFW = 2;  // software wait field width
endpackage

// File: rtl/ebw_rdy_sync.sv
module ebw_rdy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_async,
  output logic rdy_sync
);
  logic stage1_q, stage2_q;

  // falling-edge two-stage synchronizer; resets to "ready"
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b1;
      stage2_q <= 1'b1;
    end else begin
      stage1_q <= rdy_async;
      stage2_q <= stage1_q;
    end
  end

  assign rdy_sync = stage2_q;
endmodule

// File: rtl/ebw_wait_sel.sv
module ebw_wait_sel
  import ebw_pkg::*;
#(
  parameter int unsigned NCS = 4,
  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [CSW-1:0]     cs_idx,
  input  logic [NCS-1:0]     cfg_nowait,
  input  logic [WFW*NCS-1:0] cfg_swait,
  output logic               wait_en,
  output logic [WFW-1:0]     wait_cnt
);
  logic [WFW-1:0] field_per_cs [NCS];
  logic [WFW-1:0] field;

  for (genvar g = 0; g < NCS; g++) begin : g_field
    assign field_per_cs[g] = cfg_swait[g*WFW +: WFW];
  end

  assign field   = field_per_cs[cs_idx];
  assign wait_en = ~cfg_nowait[cs_idx];

  // 00->1, 01->2, 10->3, 11->3 (reserved); none when waits disabled
  always_comb begin
    if (!wait_en)             wait_cnt = '0;
    else if (field == 2'b11)  wait_cnt = 2'd3;
    else                      wait_cnt = field + 2'd1;
  end
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
  import ebw_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned NCS = 4,
  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [AW-1:0]  req_addr,
  input  logic [15:0]    req_wdata,
  input  logic           req_write,
  input  logic [1:0]     req_be,
  input  logic [CSW-1:0] req_cs,
  input  logic           sel_wait_en,
  input  logic [WFW-1:0] sel_wait_cnt,
  input  logic           rdy_s,
  input  logic [15:0]    bus_din,
  output logic [AW-1:0]  bus_addr,
  output logic [15:0]    bus_dout,
  output logic           bus_dout_oe,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_rd_n,
  output logic           bus_wr_lo_n,
  output logic           bus_wr_hi_n,
  output logic           bus_wr_n,
  output logic           bus_bhe_n,
  output logic           bus_ale,
  output logic           done,
  output logic [15:0]    rdata
);
  ebw_state_e     state_q, state_d;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q, rdata_q;
  logic           write_q, wen_q;
  logic [1:0]     be_q;
  logic [CSW-1:0] cs_q;
  logic [WFW-1:0] cnt_q, cnt_d;
  logic           accept, busy, strb_on, finish;

  assign accept  = (state_q == ST_IDLE) && req;
  assign busy    = (state_q != ST_IDLE);
  assign strb_on = (state_q == ST_STRB) || (state_q == ST_RWAIT);
  assign finish  = strb_on && (state_d == ST_END);

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE:  if (req) begin
                  state_d = ST_SETUP;
                  cnt_d   = sel_wait_cnt;
                end
      ST_SETUP: state_d = ST_STRB;
      ST_STRB:  if (cnt_q != '0)          cnt_d   = cnt_q - 1'b1;
                else if (wen_q && !rdy_s) state_d = ST_RWAIT;
                else                      state_d = ST_END;
      ST_RWAIT: if (rdy_s) state_d = ST_END;
      ST_END:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state and counter registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // request capture, enabled on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      be_q    <= '0;
      cs_q    <= '0;
      wen_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      be_q    <= req_be;
      cs_q    <= req_cs;
      wen_q   <= sel_wait_en;
    end
  end

  // read data capture on the strobe-release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (finish) rdata_q <= bus_din;
  end

  // bus outputs decoded from state and captured request
  always_comb begin
    bus_cs_n = '1;
    if (busy) bus_cs_n[cs_q] = 1'b0;
  end

  assign bus_addr    = addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_oe = busy && write_q;
  assign bus_ale     = (state_q == ST_SETUP);
  assign bus_rd_n    = !(strb_on && !write_q);
  assign bus_wr_lo_n = !(strb_on && write_q && be_q[0]);
  assign bus_wr_hi_n = !(strb_on && write_q && be_q[1]);
  assign bus_wr_n    = bus_wr_lo_n && bus_wr_hi_n;
  assign bus_bhe_n   = !(busy && be_q[1]);
  assign done        = (state_q == ST_END);
  assign rdata       = rdata_q;

  // assertions
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (bus_cs_n == '1));
  a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n));
  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_on && $past(strb_on)) |-> ($stable(bus_addr) && $stable(bus_cs_n)
      && $stable(bus_dout) && $stable(bus_rd_n) && $stable(bus_wr_n)));
  a_r5_no_rwait_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RWAIT) |-> wen_q);
  a_r9_busy_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
endmodule

// File: rtl/ebw_ctrl.sv
module ebw_ctrl
  import ebw_pkg::*;
#(
  parameter int unsigned AW  = 20,
  parameter int unsigned NCS = 4,
  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [AW-1:0]      req_addr,
  input  logic [15:0]        req_wdata,
  input  logic               req_write,
  input  logic [1:0]         req_be,
  input  logic [CSW-1:0]     req_cs,
  input  logic [NCS-1:0]     cfg_nowait,
  input  logic [WFW*NCS-1:0] cfg_swait,
  input  logic               bus_rdy,
  input  logic               bclk_off,
  input  logic [15:0]        bus_din,
  output logic [AW-1:0]      bus_addr,
  output logic [15:0]        bus_dout,
  output logic               bus_dout_oe,
  output logic [NCS-1:0]     bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_lo_n,
  output logic               bus_wr_hi_n,
  output logic               bus_wr_n,
  output logic               bus_bhe_n,
  output logic               bus_ale,
  output logic               bus_clk,
  output logic               done,
  output logic [15:0]        rdata
);
  logic           rst_s1_q, rst_s2_q;
  logic           rdy_s;
  logic           sel_wait_en;
  logic [WFW-1:0] sel_wait_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  ebw_rdy_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .rdy_async (bus_rdy),
    .rdy_sync  (rdy_s)
  );

  ebw_wait_sel #(.NCS(NCS)) u_wsel (
    .cs_idx     (req_cs),
    .cfg_nowait (cfg_nowait),
    .cfg_swait  (cfg_swait),
    .wait_en    (sel_wait_en),
    .wait_cnt   (sel_wait_cnt)
  );

  ebw_seq #(.AW(AW), .NCS(NCS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_s2_q),
    .req          (req),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_write    (req_write),
    .req_be       (req_be),
    .req_cs       (req_cs),
    .sel_wait_en  (sel_wait_en),
    .sel_wait_cnt (sel_wait_cnt),
    .rdy_s        (rdy_s),
    .bus_din      (bus_din),
    .bus_addr     (bus_addr),
    .bus_dout     (bus_dout),
    .bus_dout_oe  (bus_dout_oe),
    .bus_cs_n     (bus_cs_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_lo_n  (bus_wr_lo_n),
    .bus_wr_hi_n  (bus_wr_hi_n),
    .bus_wr_n     (bus_wr_n),
    .bus_bhe_n    (bus_bhe_n),
    .bus_ale      (bus_ale),
    .done         (done),
    .rdata        (rdata)
  );

  // bus clock follows the core clock unless parked high
  assign bus_clk = bclk_off ? 1'b1 : clk;

  a_r10_bclk_parked: assert property (@(posedge clk) disable iff (!rst_s2_q)
    bclk_off |-> bus_clk);
endmodule

// File: tb/ebw_ctrl_test.sv
module ebw_ctrl_test;
  localparam int AW = 20;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [1:0]  req_cs = '0;
  logic [3:0]  cfg_nowait = '0;
  logic [7:0]  cfg_swait = '0;
  logic        bus_rdy = 1'b1;
  logic        bclk_off = 1'b0;
  logic [15:0] bus_din = '0;
  logic [19:0] bus_addr;
  logic [15:0] bus_dout, rdata;
  logic        bus_dout_oe, bus_rd_n, bus_wr_lo_n, bus_wr_hi_n, bus_wr_n;
  logic        bus_bhe_n, bus_ale, bus_clk, done;
  logic [3:0]  bus_cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ebw_ctrl #(.AW(AW), .NCS(NCS)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_be(req_be),
    .req_cs(req_cs), .cfg_nowait(cfg_nowait), .cfg_swait(cfg_swait),
    .bus_rdy(bus_rdy), .bclk_off(bclk_off), .bus_din(bus_din),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_lo_n(bus_wr_lo_n),
    .bus_wr_hi_n(bus_wr_hi_n), .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n),
    .bus_ale(bus_ale), .bus_clk(bus_clk), .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_waits(input bit nowait, input logic [1:0] fld);
    if (nowait) return 0;
    return (fld == 2'b11) ? 3 : int'(fld) + 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic xfer(input logic [1:0] cs, input bit wr, input logic [1:0] be,
                      input logic [19:0] a, input logic [15:0] wd,
                      input logic [15:0] din, input bit hold_low);
    int waits, strb_cnt, exp_strb, release_at;
    bit wen, saw_done;
    logic [3:0] exp_cs;
    waits = exp_waits(cfg_nowait[cs], cfg_swait[cs*2 +: 2]);
    wen = !cfg_nowait[cs];
    exp_cs = ~(4'b1 << cs);
    release_at = waits + 3;
    if (hold_low) begin
      bus_rdy = 1'b0;
      tick(); tick(); tick();
    end
    exp_strb = (hold_low && wen) ? release_at + 1 : waits + 1;
    req = 1'b1; req_cs = cs; req_write = wr; req_be = be;
    req_addr = a; req_wdata = wd; bus_din = din;
    tick();
    req = 1'b0;
    // setup cycle
    chk(bus_ale == 1'b1 && bus_cs_n == exp_cs && bus_addr == a, "R2 setup",
        {bus_ale, bus_cs_n, bus_addr}, {1'b1, exp_cs, a});
    chk(bus_rd_n && bus_wr_n, "R2 strobes idle in setup", {bus_rd_n, bus_wr_n}, 2'b11);
    strb_cnt = 0;
    saw_done = 0;
    for (int k = 0; k < 40 && !saw_done; k++) begin
      tick();
      if (done) begin
        saw_done = 1;
        chk(bus_rd_n && bus_wr_n, "R8 strobes released", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(strb_cnt == exp_strb, hold_low ? (wen ? "R6 ready wait length" : "R5 ready ignored")
            : (wen ? "R4 software waits" : "R5 no-wait strobe"), strb_cnt, exp_strb);
        if (!wr) chk(rdata == din, "R8 read data", rdata, din);
      end else begin
        strb_cnt++;
        if (wr) begin
          chk(bus_rd_n && bus_wr_lo_n == !be[0] && bus_wr_hi_n == !be[1] && !bus_wr_n
              && bus_dout_oe && bus_dout == wd, "R3 write strobes",
              {bus_rd_n, bus_wr_lo_n, bus_wr_hi_n, bus_wr_n, bus_dout_oe},
              {1'b1, !be[0], !be[1], 1'b0, 1'b1});
        end else begin
          chk(!bus_rd_n && bus_wr_n && !bus_dout_oe, "R3 read strobe",
              {bus_rd_n, bus_wr_n, bus_dout_oe}, 3'b010);
        end
        chk(bus_bhe_n == !be[1], "R3 byte-high enable", bus_bhe_n, !be[1]);
        chk(bus_addr == a && bus_cs_n == exp_cs && !bus_ale, "R7 frozen outputs",
            {bus_addr, bus_cs_n, bus_ale}, {a, exp_cs, 1'b0});
        if (strb_cnt == 1) begin
          req = 1'b1; req_addr = ~a; req_cs = cs + 2'd1;  // R9 stray request
        end else begin
          req = 1'b0;
        end
        if (hold_low && wen && strb_cnt == release_at) bus_rdy = 1'b1;
      end
    end
    req = 1'b0;
    chk(saw_done, "R8 done seen", saw_done, 1);
    tick();
    chk(bus_cs_n == 4'hF && !done && !bus_ale, "R9 idle after done, stray request ignored",
        {bus_cs_n, done}, {4'hF, 1'b0});
    bus_rdy = 1'b1;
    tick(); tick(); tick();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(bus_cs_n == 4'hF && bus_rd_n && bus_wr_lo_n && bus_wr_hi_n && bus_wr_n
        && !bus_ale && !bus_dout_oe && !done, "R1 reset state",
        {bus_cs_n, bus_rd_n, bus_wr_n, bus_ale, done}, {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk(bus_cs_n == 4'hF && !done, "R1 idle after reset release", bus_cs_n, 4'hF);

    // R10 bus clock
    chk(bus_clk == 1'b1, "R10 bclk high phase", bus_clk, 1);
    @(negedge clk); #2;
    chk(bus_clk == 1'b0, "R10 bclk follows clk", bus_clk, 0);
    bclk_off = 1'b1;
    #1;
    chk(bus_clk == 1'b1, "R10 bclk parked", bus_clk, 1);
    tick();
    chk(bus_clk == 1'b1, "R10 bclk parked high", bus_clk, 1);
    bclk_off = 1'b0;

    // directed corners: every wait field, no-wait with ready low, ready wait
    cfg_nowait = 4'b0000;
    cfg_swait = {2'b11, 2'b10, 2'b01, 2'b00};
    xfer(2'd0, 1'b0, 2'b11, 20'h12345, 16'h0, 16'hBEEF, 1'b0);  // R4 field 00
    xfer(2'd1, 1'b1, 2'b01, 20'h00ABC, 16'hA55A, 16'h0, 1'b0); // R4 field 01
    xfer(2'd2, 1'b1, 2'b10, 20'hFFFFF, 16'h1234, 16'h0, 1'b0); // R4 field 10
    xfer(2'd3, 1'b0, 2'b01, 20'h54321, 16'h0, 16'hC0DE, 1'b0); // R4 field 11
    xfer(2'd0, 1'b0, 2'b11, 20'h00001, 16'h0, 16'h7777, 1'b1); // R6 ready wait
    cfg_nowait = 4'b0100;
    xfer(2'd2, 1'b0, 2'b11, 20'h0F0F0, 16'h0, 16'h9999, 1'b1); // R5 ready ignored
    xfer(2'd2, 1'b1, 2'b10, 20'h0A0A0, 16'hFACE, 16'h0, 1'b0); // R5 one-cycle strobe

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] be;
      cfg_nowait = 4'($urandom);
      cfg_swait = 8'($urandom);
      be = 2'($urandom);
      if (be == 2'b00) be = 2'b01;
      xfer(2'($urandom), 1'($urandom), be, 20'($urandom), 16'($urandom),
           16'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule